// File: doc/BRIEF.md
# Capture-Phase Sweep Delay Controller

This block measures the delay of a logic path by running the same two-vector launch/capture test again and again. Before each run it moves the capture clock earlier relative to the launch clock. It drives a phase code to an external phase shifter and fires a start strobe at a separate launch/capture engine. It then waits for that engine's done flag and compares the value the capture flop took with the value the second vector should produce.

As long as the capture matches, the phase code is lowered by a fixed step and the test is repeated. Only two clock edges are involved in each test, so a path of any length can be timed. The sweep ends at the first mismatch, and the last phase code that still passed is reported as the delay estimate.

A sweep can also end in two other ways. A mismatch on the very first test is reported as an overflow. A sweep that reaches the minimum phase without failing is reported as an underflow, and the result is the minimum code.

Top module: `phase_sweep_ctrl`

## Requirements
- R1: When `start` is sampled high while idle, the block latches the step size and the minimum phase. It loads `phaseCode` with the larger of `initPhase` and `minPhase`, and raises `testStart` for exactly one cycle in the cycle after `start` was sampled.
- R2: Only one test is in flight at a time. After a `testStart` pulse, no further `testStart` is issued until `testDone` has been sampled high.
- R3: A test passes when `capturedVal` equals `expectVal` in the cycle `testDone` is high. If it passes while `phaseCode` is above the minimum, `phaseCode` drops by the step size, but never below the minimum, and a new `testStart` pulse follows in the next cycle.
- R4: A failing test that follows at least one passing test ends the sweep. `result` is set to the last phase code that passed, and `overflowFlag` and `underflowFlag` are both 0.
- R5: If the first test of a sweep fails, the sweep ends with `overflowFlag` set to 1, `underflowFlag` set to 0 and `result` set to 0.
- R6: A passing test at the minimum phase ends the sweep with `underflowFlag` set to 1, `overflowFlag` set to 0 and `result` equal to the minimum phase.
- R7: `valid` is high for exactly one cycle when a sweep ends, and it only follows a cycle in which `testDone` was high. `result` and both flags keep their values until the next sweep ends. After reset all outputs are 0.
- R8: A step size of 0 is treated as a step of 1.
- R9: `start` pulses while a sweep is running are ignored and do not change its result.
- R10: `phaseCode` does not change while a test is in flight, that is, from a `testStart` pulse until `testDone` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (ignored when busy) |
| initPhase | input | PHASE_W | Phase code of the first test |
| stepSize | input | PHASE_W | Phase decrement per passing test |
| minPhase | input | PHASE_W | Lowest phase code the sweep may use |
| expectVal | input | DATA_W | Value the second vector should produce |
| capturedVal | input | DATA_W | Value taken by the capture flop |
| testDone | input | 1 | The launch/capture engine has finished the test |
| phaseCode | output | PHASE_W | Capture phase code sent to the phase shifter |
| testStart | output | 1 | One-cycle strobe that starts a test |
| result | output | PHASE_W | Last passing phase code (delay estimate) |
| overflowFlag | output | 1 | The first test already failed |
| underflowFlag | output | 1 | The minimum phase was reached without a failure |
| valid | output | 1 | One-cycle pulse when a sweep ends |

## Verification
The bench drives a responder that passes a test whenever the phase code is at or above a hidden threshold. This places the failure point at an interior step, at the first step, or beyond the minimum. A design that reported the failing code instead of the last passing one would be off by one step. A design that skipped the clamp to the minimum would wrap past zero and never report underflow. Further cases cover a zero step, which would otherwise hang the sweep, and an initial phase below the minimum, which must be raised to the minimum. A stray `start` pulse mid-sweep must not restart the sweep or shift its result. The responder also counts any test strobe that arrives while a test is still pending.

// File: rtl/phase_sweep_pkg.sv
package phase_sweep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } sweepState_t;

  typedef struct packed {
    logic loadInit;
    logic stepDown;
    logic endAtMin;
    logic endOnFail;
  } sweepStrobe_t;

endpackage

// File: rtl/sweep_dp.sv
module sweep_dp
  import phase_sweep_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int DATA_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  sweepStrobe_t       strobe,
  input  logic [PHASE_W-1:0] initPhase,
  input  logic [PHASE_W-1:0] stepSize,
  input  logic [PHASE_W-1:0] minPhase,
  input  logic [DATA_W-1:0]  expectVal,
  input  logic [DATA_W-1:0]  capturedVal,
  output logic [PHASE_W-1:0] phaseCode,
  output logic               atMin,
  output logic               captureMatch,
  output logic [PHASE_W-1:0] result,
  output logic               overflowFlag,
  output logic               underflowFlag,
  output logic               valid
);

  localparam logic [PHASE_W-1:0] ONE_STEP = {{(PHASE_W-1){1'b0}}, 1'b1};

  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W-1:0] minQ;
  logic [PHASE_W-1:0] stepQ;
  logic [PHASE_W-1:0] lastPassQ;
  logic               passedAnyQ;
  logic [PHASE_W-1:0] resultQ;
  logic               ovfQ;
  logic               unfQ;
  logic               validQ;

  logic [PHASE_W-1:0] headroom;
  logic [PHASE_W-1:0] nextPhase;
  logic [PHASE_W-1:0] firstPhase;
  logic [PHASE_W-1:0] stepEff;

  assign firstPhase = (initPhase < minPhase) ? minPhase : initPhase;
  assign stepEff    = (stepSize == '0) ? ONE_STEP : stepSize;
  assign headroom   = phaseQ - minQ;
  assign nextPhase  = (headroom > stepQ) ? (phaseQ - stepQ) : minQ;

  assign atMin        = (phaseQ <= minQ);
  assign captureMatch = (capturedVal == expectVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ     <= '0;
      minQ       <= '0;
      stepQ      <= ONE_STEP;
      lastPassQ  <= '0;
      passedAnyQ <= 1'b0;
      resultQ    <= '0;
      ovfQ       <= 1'b0;
      unfQ       <= 1'b0;
      validQ     <= 1'b0;
    end else begin
      validQ <= 1'b0;
      if (strobe.loadInit) begin
        phaseQ     <= firstPhase;
        minQ       <= minPhase;
        stepQ      <= stepEff;
        lastPassQ  <= '0;
        passedAnyQ <= 1'b0;
      end
      if (strobe.stepDown) begin
        lastPassQ  <= phaseQ;
        passedAnyQ <= 1'b1;
        phaseQ     <= nextPhase;
      end
      if (strobe.endAtMin) begin
        resultQ <= phaseQ;
        ovfQ    <= 1'b0;
        unfQ    <= 1'b1;
        validQ  <= 1'b1;
      end
      if (strobe.endOnFail) begin
        resultQ <= passedAnyQ ? lastPassQ : '0;
        ovfQ    <= !passedAnyQ;
        unfQ    <= 1'b0;
        validQ  <= 1'b1;
      end
    end
  end

  assign phaseCode     = phaseQ;
  assign result        = resultQ;
  assign overflowFlag  = ovfQ;
  assign underflowFlag = unfQ;
  assign valid         = validQ;

endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
  import phase_sweep_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         testDone,
  input  logic         atMin,
  input  logic         captureMatch,
  output sweepStrobe_t strobe,
  output logic         testStart
);

  sweepState_t stateQ;
  sweepState_t stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.loadInit = 1'b1;
          stateD          = ST_ISSUE;
        end
      end
      ST_ISSUE: stateD = ST_WAIT;
      ST_WAIT: begin
        if (testDone) begin
          if (!captureMatch) begin
            strobe.endOnFail = 1'b1;
            stateD           = ST_IDLE;
          end else if (atMin) begin
            strobe.endAtMin = 1'b1;
            stateD          = ST_IDLE;
          end else begin
            strobe.stepDown = 1'b1;
            stateD          = ST_ISSUE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign testStart = (stateQ == ST_ISSUE);

endmodule

// File: rtl/phase_sweep_ctrl.sv
module phase_sweep_ctrl
  import phase_sweep_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int DATA_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [PHASE_W-1:0] initPhase,
  input  logic [PHASE_W-1:0] stepSize,
  input  logic [PHASE_W-1:0] minPhase,
  input  logic [DATA_W-1:0]  expectVal,
  input  logic [DATA_W-1:0]  capturedVal,
  input  logic               testDone,
  output logic [PHASE_W-1:0] phaseCode,
  output logic               testStart,
  output logic [PHASE_W-1:0] result,
  output logic               overflowFlag,
  output logic               underflowFlag,
  output logic               valid
);

  sweepStrobe_t strobe;
  logic         atMin;
  logic         captureMatch;

  sweep_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .testDone     (testDone),
    .atMin        (atMin),
    .captureMatch (captureMatch),
    .strobe       (strobe),
    .testStart    (testStart)
  );

  sweep_dp #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .initPhase     (initPhase),
    .stepSize      (stepSize),
    .minPhase      (minPhase),
    .expectVal     (expectVal),
    .capturedVal   (capturedVal),
    .phaseCode     (phaseCode),
    .atMin         (atMin),
    .captureMatch  (captureMatch),
    .result        (result),
    .overflowFlag  (overflowFlag),
    .underflowFlag (underflowFlag),
    .valid         (valid)
  );

endmodule

// File: rtl/phase_sweep_chk.sv
module phase_sweep_chk #(
  parameter int PHASE_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               testDone,
  input logic [PHASE_W-1:0] phaseCode,
  input logic               testStart,
  input logic [PHASE_W-1:0] result,
  input logic               overflowFlag,
  input logic               underflowFlag,
  input logic               valid
);

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> !testStart);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);

  // R7
  valid_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> $past(testDone));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && overflowFlag) |-> (result == '0 && !underflowFlag));

  // R6
  no_underflow_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && underflowFlag) |-> !overflowFlag);

  // R10
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> $stable(phaseCode));

endmodule

bind phase_sweep_ctrl phase_sweep_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .testDone      (testDone),
  .phaseCode     (phaseCode),
  .testStart     (testStart),
  .result        (result),
  .overflowFlag  (overflowFlag),
  .underflowFlag (underflowFlag),
  .valid         (valid)
);

// File: tb/sim_phase_sweep_ctrl.sv
module sim_phase_sweep_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic [PW-1:0] initPhase, stepSize, minPhase;
  logic [DW-1:0] expectVal, capturedVal;
  logic          testDone;
  logic [PW-1:0] phaseCode, result;
  logic          testStart, overflowFlag, underflowFlag, valid;

  int checks = 0;
  int fails  = 0;
  int thr    = 0;
  int lat    = 2;
  int issued = 0;
  int extraStarts = 0;
  int phaseMoved  = 0;
  int lastTestedPh = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_sweep_ctrl #(.PHASE_W(PW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .initPhase(initPhase),
    .stepSize(stepSize), .minPhase(minPhase), .expectVal(expectVal),
    .capturedVal(capturedVal), .testDone(testDone), .phaseCode(phaseCode),
    .testStart(testStart), .result(result), .overflowFlag(overflowFlag),
    .underflowFlag(underflowFlag), .valid(valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Launch/capture engine model: passes while phaseCode >= thr
  initial begin
    testDone = 1'b0;
    capturedVal = '0;
    forever begin
      @(negedge clk);
      testDone = 1'b0;
      if (testStart) begin
        int ph;
        issued++;
        ph = int'(phaseCode);
        lastTestedPh = ph;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (testStart) extraStarts++;
          if (int'(phaseCode) != ph) phaseMoved++;
        end
        capturedVal = (int'(phaseCode) >= thr) ? expectVal : ~expectVal;
        testDone = 1'b1;
      end
    end
  end

  task automatic model(input int init, input int step, input int mn,
                       input int th, output int res, output bit ovf,
                       output bit unf, output int iters, output int lastPh);
    int p, s, np;
    p = (init < mn) ? mn : init;
    s = (step == 0) ? 1 : step;
    iters = 1; lastPh = p; ovf = 0; unf = 0; res = 0;
    if (p < th) begin ovf = 1; return; end
    while (1'b1) begin
      if (p <= mn) begin unf = 1; res = mn; return; end
      np = (p - mn > s) ? p - s : mn;
      iters++; lastPh = np;
      if (np < th) begin res = p; return; end
      p = np;
    end
  endtask

  task automatic waitValid(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (valid) begin seen = 1; return; end
    end
  endtask

  task automatic runSweep(input int init, input int step, input int mn,
                          input int th, input int l, input bit busyPoke,
                          input string req);
    int eRes, eIt, eLast;
    bit eOvf, eUnf, seen;
    int firstPh;
    model(init, step, mn, th, eRes, eOvf, eUnf, eIt, eLast);
    firstPh = (init < mn) ? mn : init;
    @(negedge clk);
    thr = th; lat = l; issued = 0; extraStarts = 0; phaseMoved = 0;
    initPhase = PW'(init); stepSize = PW'(step); minPhase = PW'(mn);
    expectVal = DW'(init);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: first test strobe and phase one cycle after start
    chk(testStart == 1'b1, "R1", "testStart after start", int'(testStart), 1);
    chk(int'(phaseCode) == firstPh, "R1", "first phase", int'(phaseCode), firstPh);
    if (busyPoke) begin
      repeat (3) @(negedge clk);
      initPhase = PW'(init + 40); minPhase = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      initPhase = PW'(init); minPhase = PW'(mn);
    end
    waitValid(seen);
    chk(seen, req, "valid seen", int'(seen), 1);
    chk(int'(result) == eRes, req, "result", int'(result), eRes);
    chk(overflowFlag == eOvf, "R5", "overflow flag", int'(overflowFlag), int'(eOvf));
    chk(underflowFlag == eUnf, "R6", "underflow flag", int'(underflowFlag), int'(eUnf));
    chk(issued == eIt, busyPoke ? "R9" : "R3", "test count", issued, eIt);
    chk(lastTestedPh == eLast, "R3", "last tested phase", lastTestedPh, eLast);
    chk(extraStarts == 0, "R2", "strobes while pending", extraStarts, 0);
    chk(phaseMoved == 0, "R10", "phase moved in flight", phaseMoved, 0);
    @(negedge clk);
    chk(valid == 1'b0, "R7", "valid one cycle", int'(valid), 0);
    chk(int'(result) == eRes, "R7", "result held", int'(result), eRes);
  endtask

  task automatic resetCheck();
    rstN = 1'b0; start = 1'b0;
    initPhase = '0; stepSize = '0; minPhase = '0; expectVal = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(phaseCode == '0, "R7", "reset phaseCode", int'(phaseCode), 0);
    chk(result == '0, "R7", "reset result", int'(result), 0);
    chk(!valid && !testStart, "R7", "reset valid/testStart", int'(valid) + int'(testStart), 0);
    chk(!overflowFlag && !underflowFlag, "R7", "reset flags",
        int'(overflowFlag) + int'(underflowFlag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    resetCheck();
    // R4: interior failure, result = last passing code (150)
    runSweep(200, 10, 20, 143, 2, 1'b0, "R4");
    // R5: first test already fails
    runSweep(100, 10, 0, 120, 1, 1'b0, "R5");
    // R6: reaches minimum 30 with clamped last step
    runSweep(60, 7, 30, 5, 3, 1'b0, "R6");
    // R8: zero step behaves as step 1, result 7
    runSweep(10, 0, 0, 7, 1, 1'b0, "R8");
    // R1: initial phase below minimum is raised to minimum
    runSweep(5, 4, 12, 0, 2, 1'b0, "R1");
    // R9: start pulse during a sweep is ignored
    runSweep(90, 5, 10, 61, 4, 1'b1, "R9");
    // R4 again with a long engine latency
    runSweep(255, 50, 0, 100, 6, 1'b0, "R4");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule